// File: doc/BRIEF.md
# Dual-Port Sample Demultiplexer

This block sits behind a converter that delivers one 8-bit unsigned code per accepted sample. It presents those codes on two registered output ports, A and B, and offers two operating modes. In straight mode every sample appears on port A with one clock of latency, and port B is left alone. In paired mode an internal half-rate phase steers the samples. The first sample of a pair is held internally. The second sample makes A and B update together, so that each port runs at half the sample rate.

A polarity input selects true or complemented codes for both ports. The value of this input is taken when a sample is accepted. The mode input is only sampled while reset is asserted, so a pair can never be torn by a mode change. Reset also clears the pair phase. A reset applied in common to several instances on one clock therefore leaves all of them pairing the same samples. An output strobe marks the cycles in which fresh data is on the ports.

The input is a valid/ready stream. `s_ready` is low only while reset is held and for one clock after it. At all other times every sample offered with `s_valid` is taken. The output side has no back-pressure, because a converter cannot be stalled. `out_stb` acts as the output valid, and downstream logic must capture the ports at the clock edge that ends each cycle in which `out_stb` is high.

Top module: `adm_top`

## Requirements
- R1: While `rst` is high, and for one clock after it falls, `s_ready` is low. After any reset cycle, `a_data`, `b_data` and `out_stb` are all zero.
- R2: In straight mode (mode captured as 0), a sample accepted at a clock edge appears on `a_data` at that same edge, and `out_stb` is high for the following cycle.
- R3: In straight mode, `b_data` never changes.
- R4: In paired mode (mode captured as 1), the first accepted sample after reset, and every odd sample after it, is held internally. At that edge `a_data` does not change and `out_stb` stays low. The next accepted sample puts the held code on `a_data` and the new code on `b_data` at the same edge, and `out_stb` is high for one cycle.
- R5: With `pol_true` high when a sample is accepted, the code passes unchanged. With it low, the bitwise complement is used, so 8'hFF becomes 8'h00. This holds for both ports and both modes.
- R6: `mode_sel` is captured only in cycles where `rst` is high. Changing it at any other time has no effect on routing.
- R7: A reset in the middle of a pair discards the held code. The first sample after reset goes to port A.
- R8: A cycle without an accepted sample leaves the ports unchanged, keeps `out_stb` low, and does not advance the pair phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high; clears phase, captures mode |
| mode_sel | input | 1 | 0 = straight, 1 = paired; sampled during reset only |
| pol_true | input | 1 | 1 = true code, 0 = complemented code |
| s_valid | input | 1 | Input sample valid |
| s_data | input | 8 | Input sample code |
| s_ready | output | 1 | Input ready |
| a_data | output | 8 | Port A code |
| b_data | output | 8 | Port B code |
| out_stb | output | 1 | Port data fresh this cycle |

## Verification
The hardest state to reach from the ports is a half-filled pair that is then cut short. This covers a reset landing between the two samples of a pair, and also a gap in `s_valid` landing in the same place. The stimulus reaches it by resetting one cycle after a single paired-mode sample, and by inserting idle cycles after odd samples. The reference model's queue of held codes then shows whether the stale code leaked out. Mode flips without reset are mixed into both modes, to show that routing stays put.

// File: rtl/adm_pkg.sv
package adm_pkg;
  typedef enum logic {
    MODE_STRAIGHT = 1'b0,
    MODE_PAIRED   = 1'b1
  } adm_mode_e;
endpackage

// File: rtl/adm_polarity.sv
module adm_polarity #(
  parameter int W = 8
) (
  input  logic         true_i,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] code_o
);
  always_comb code_o = true_i ? code_i : ~code_i;
endmodule

// File: rtl/adm_phase.sv
module adm_phase (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  output logic ph_o
);
  always_ff @(posedge clk) begin
    if (rst)        ph_o <= 1'b0;
    else if (adv_i) ph_o <= ~ph_o;
  end

  AST_PHASE_CLEARED: assert property (@(posedge clk) rst |=> !ph_o); // R7
  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(ph_o)); // R8
endmodule

// File: rtl/adm_ports.sv
module adm_ports
  import adm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  adm_mode_e    mode_i,
  input  logic         acc_i,
  input  logic         ph_i,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         stb_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_o    <= '0;
      b_o    <= '0;
      held_q <= '0;
      stb_o  <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      if (acc_i) begin
        if (mode_i == MODE_STRAIGHT) begin
          a_o   <= code_i;
          stb_o <= 1'b1;
        end else if (!ph_i) begin
          held_q <= code_i;
        end else begin
          a_o   <= held_q;
          b_o   <= code_i;
          stb_o <= 1'b1;
        end
      end
    end
  end

  AST_B_STILL_STRAIGHT: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_STRAIGHT) |=> $stable(b_o)); // R3
  AST_FIRST_OF_PAIR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_PAIRED && acc_i && !ph_i) |=> (!stb_o && $stable(a_o))); // R4
  AST_NO_STB_IDLE: assert property (@(posedge clk) disable iff (rst)
    !acc_i |=> (!stb_o && $stable(a_o) && $stable(b_o))); // R8
endmodule

// File: rtl/adm_top.sv
module adm_top
  import adm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_sel,
  input  logic         pol_true,
  input  logic         s_valid,
  input  logic [W-1:0] s_data,
  output logic         s_ready,
  output logic [W-1:0] a_data,
  output logic [W-1:0] b_data,
  output logic         out_stb
);
  adm_mode_e    mode_q;
  logic         rdy_q;
  logic         acc;
  logic         ph;
  logic [W-1:0] code_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= adm_mode_e'(mode_sel);
      rdy_q  <= 1'b0;
    end else begin
      rdy_q  <= 1'b1;
    end
  end

  assign s_ready = rdy_q;
  assign acc     = s_valid & rdy_q;

  adm_polarity #(.W(W)) u_pol (
    .true_i (pol_true),
    .code_i (s_data),
    .code_o (code_p)
  );

  adm_phase u_phase (
    .clk   (clk),
    .rst   (rst),
    .adv_i (acc && mode_q == MODE_PAIRED),
    .ph_o  (ph)
  );

  adm_ports #(.W(W)) u_ports (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode_q),
    .acc_i  (acc),
    .ph_i   (ph),
    .code_i (code_p),
    .a_o    (a_data),
    .b_o    (b_data),
    .stb_o  (out_stb)
  );

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q)); // R6
  AST_NOT_READY_AFTER_RESET: assert property (@(posedge clk)
    rst |=> (!s_ready && a_data == '0 && b_data == '0 && !out_stb)); // R1
endmodule

// File: tb/test_adm_top.sv
module test_adm_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_sel = 1'b0;
  logic       pol_true = 1'b1;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_ready;
  logic [7:0] a_data, b_data;
  logic       out_stb;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  logic       m_rdy = 1'b0, m_stb = 1'b0, m_mode = 1'b0;
  logic [7:0] m_a = '0, m_b = '0;
  logic [7:0] m_q[$];

  always #2 clk = ~clk;

  adm_top i_adm_top (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .pol_true(pol_true),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .a_data(a_data), .b_data(b_data), .out_stb(out_stb)
  );

  // behavioural reference, evaluated on each rising edge
  always @(posedge clk) begin
    logic [7:0] c;
    cycles++;
    if (rst) begin
      m_rdy = 1'b0; m_a = '0; m_b = '0; m_stb = 1'b0;
      m_mode = mode_sel; m_q.delete();
    end else begin
      m_stb = 1'b0;
      if (s_valid && m_rdy) begin
        c = pol_true ? s_data : ~s_data;
        if (!m_mode) begin
          m_a = c; m_stb = 1'b1;
        end else if (m_q.size() == 0) begin
          m_q.push_back(c);
        end else begin
          m_a = m_q.pop_front(); m_b = c; m_stb = 1'b1;
        end
      end
      m_rdy = 1'b1;
    end
  end

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    chk("s_ready", {7'd0, s_ready}, {7'd0, m_rdy});
    chk("a_data", a_data, m_a);
    chk("b_data", b_data, m_b);
    chk("out_stb", {7'd0, out_stb}, {7'd0, m_stb});
  end

  task automatic drive(logic v, logic [7:0] d);
    @(negedge clk);
    s_valid = v;
    s_data = d;
  endtask

  task automatic do_reset(logic m);
    @(negedge clk);
    rst = 1'b1; s_valid = 1'b0; mode_sel = m;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    cur_req = "R1";
    do_reset(1'b0);
    drive(1'b0, 8'h00);
    drive(1'b0, 8'h00);

    cur_req = "R2";
    for (int i = 0; i < 12; i++) drive(1'b1, 8'($urandom));
    drive(1'b1, 8'hFF);
    drive(1'b1, 8'h00);

    cur_req = "R3";
    for (int i = 0; i < 8; i++) drive(1'b1, 8'($urandom));

    cur_req = "R5";
    pol_true = 1'b0;
    drive(1'b1, 8'hFF);
    drive(1'b1, 8'h00);
    drive(1'b1, 8'h5A);
    pol_true = 1'b1;

    cur_req = "R8";
    for (int i = 0; i < 10; i++) drive(i % 3 == 0, 8'($urandom));

    cur_req = "R6";
    mode_sel = 1'b1;
    for (int i = 0; i < 6; i++) drive(1'b1, 8'($urandom));

    cur_req = "R1";
    do_reset(1'b1);
    drive(1'b0, 8'h00);

    cur_req = "R4";
    for (int i = 0; i < 14; i++) drive(1'b1, 8'($urandom));
    drive(1'b0, 8'h00);

    cur_req = "R8";
    drive(1'b1, 8'h11);
    drive(1'b0, 8'h00);
    drive(1'b0, 8'h00);
    drive(1'b1, 8'h22);
    for (int i = 0; i < 12; i++) drive(i % 2 == 0, 8'($urandom));

    cur_req = "R5";
    for (int i = 0; i < 8; i++) begin
      pol_true = i[0];
      drive(1'b1, (i % 4 == 1) ? 8'hFF : 8'($urandom));
    end
    pol_true = 1'b1;

    cur_req = "R6";
    mode_sel = 1'b0;
    for (int i = 0; i < 6; i++) drive(1'b1, 8'($urandom));

    cur_req = "R7";
    drive(1'b1, 8'hA5);
    drive(1'b0, 8'h00);
    do_reset(1'b1);
    drive(1'b0, 8'h00);
    drive(1'b1, 8'h3C);
    drive(1'b1, 8'hC3);
    drive(1'b1, 8'h77);
    drive(1'b0, 8'h00);
    drive(1'b0, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule